// File: doc/BRIEF.md
# Shared-Offset Framing and Bank Selector Register

This block is the register slice of a serial port controller in which two registers occupy one host I/O offset. The first is the framing register. Its fields set the character length, the stop-bit length, parity generation and the forced-break condition for the transmit and receive engines. The second is the bank selector. It picks which register bank later host accesses reach, and the block decodes it into a 2-bit bank index for the rest of the controller.

Bit 7 of the written data decides what a host write to the shared offset does. When bit 7 is clear, the value goes into both registers. When bit 7 is set, only the bank selector changes, so that moving to a high bank cannot disturb the framing.

A read at the shared offset returns the bank selector. The framing value can be read only through a read-only shadow location at offset 1 while bank 3 is selected. In consumer-IR mode the framing fields have no effect, and the block drives them all low.

Top module: `lcr_bank_regs`

## Requirements
- R1: After reset, the framing register and the bank selector both hold 00h, the bank index is 0, host_rdata is 00h, and every framing output is low.
- R2: A host write at offset 3 with data bit 7 equal to 0 stores the data into both the framing register and the bank selector. The new values are visible on the outputs on the clock cycle after the write.
- R3: A host write at offset 3 with data bit 7 equal to 1 stores the data into the bank selector only. The framing register keeps its previous value.
- R4: A host read at offset 3 returns the bank selector in any bank. host_rdata is updated on the clock edge that samples host_rd and holds until the next read.
- R5: A host read at offset 1 while the bank index is 3 returns the framing register (the shadow location).
- R6: A host write at the shadow location, or at any offset other than 3, changes neither register. Reading the shadow location changes neither register.
- R7: The bank index is 0 when bank selector bit 7 is 0. When bit 7 is 1, the bank index is bits 1:0 of the bank selector, except that 00 in those bits gives bank 1.
- R8: Outside consumer-IR mode, the framing outputs follow the framing register: fmt_char_len is bits 1:0, fmt_stop_long is bit 2, fmt_par_en is bit 3, fmt_par_even is bit 4, fmt_par_stick is bit 5 and fmt_break is bit 6.
- R9: While cir_mode is 1, all framing outputs are driven to 0 and the stored framing value is not altered.
- R10: A host read at any location other than offset 3, or offset 1 in bank 3, returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host I/O offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cir_mode | input | 1 | Consumer-IR mode: framing fields inactive |
| bank_idx | output | 2 | Decoded current register bank |
| fmt_char_len | output | 2 | Character length code |
| fmt_stop_long | output | 1 | Long stop-bit select |
| fmt_par_en | output | 1 | Parity enable |
| fmt_par_even | output | 1 | Even parity select |
| fmt_par_stick | output | 1 | Stick parity select |
| fmt_break | output | 1 | Force break on transmit front end |

## Verification
A write is captured at one clock edge, and the register outputs, bank index and framing fields change at that edge with no further delay. The bench drives each access at a falling edge, removes it at the next falling edge, and checks the outputs there, half a cycle after the capturing edge. A read is registered, so host_rdata is compared at the falling edge after the rising edge that sampled host_rd, and the expected value is taken from the model state before that read. cir_mode acts combinationally and is checked half a cycle after it changes, with no clock edge needed.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    // Host offsets whose meaning the rest of the controller relies on
    localparam int unsigned HOST_ADDR_W  = 3;
    localparam int unsigned HOST_DATA_W  = 8;
    localparam int unsigned BANK_IDX_W   = 2;
    localparam int unsigned OFS_SHARED   = 3;
    localparam int unsigned OFS_SHADOW   = 1;
    localparam int unsigned BANK_SHADOW  = 3;

    // Framing field layout (bit positions are decoded by the serial engines)
    localparam int unsigned FLD_LEN_LO   = 0;
    localparam int unsigned FLD_STOP     = 2;
    localparam int unsigned FLD_PAR_EN   = 3;
    localparam int unsigned FLD_EVEN     = 4;
    localparam int unsigned FLD_STICK    = 5;
    localparam int unsigned FLD_BREAK    = 6;

    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] char_len;
    } fmt_fields_t;

endpackage

// File: rtl/lcr_wr_ctrl.sv
module lcr_wr_ctrl #(
    parameter int unsigned ADDR_W     = lcr_pkg::HOST_ADDR_W,
    parameter int unsigned DATA_W     = lcr_pkg::HOST_DATA_W,
    parameter int unsigned SHARED_OFS = lcr_pkg::OFS_SHARED
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] link_q,
    input  logic [DATA_W-1:0] bsel_q,
    output logic [DATA_W-1:0] link_d,
    output logic [DATA_W-1:0] bsel_d
);
    localparam int unsigned SEL_BIT = DATA_W - 1;
    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_OFS);

    logic hit_shared;
    logic keep_link;

    always_comb begin
        hit_shared = wr_en && (addr == SHARED_A);
        // Bit 7 set: selector-only write, framing is protected
        keep_link  = wdata[SEL_BIT];

        link_d = link_q;
        bsel_d = bsel_q;
        if (hit_shared) begin
            bsel_d = wdata;
            if (!keep_link) begin
                link_d = wdata;
            end
        end
    end

endmodule

// File: rtl/lcr_bank_dec.sv
module lcr_bank_dec #(
    parameter int unsigned DATA_W = lcr_pkg::HOST_DATA_W,
    parameter int unsigned BANK_W = lcr_pkg::BANK_IDX_W
) (
    input  logic [DATA_W-1:0] bsel_q,
    output logic [BANK_W-1:0] bank_idx
);
    localparam int unsigned SEL_BIT = DATA_W - 1;
    localparam logic [BANK_W-1:0] BANK_ZERO = '0;
    localparam logic [BANK_W-1:0] BANK_ONE  = BANK_W'(1);

    logic [BANK_W-1:0] low_field;

    always_comb begin
        low_field = bsel_q[BANK_W-1:0];
        if (!bsel_q[SEL_BIT]) begin
            bank_idx = BANK_ZERO;
        end else if (low_field == BANK_ZERO) begin
            bank_idx = BANK_ONE;
        end else begin
            bank_idx = low_field;
        end
    end

endmodule

// File: rtl/lcr_rd_mux.sv
module lcr_rd_mux #(
    parameter int unsigned ADDR_W      = lcr_pkg::HOST_ADDR_W,
    parameter int unsigned DATA_W      = lcr_pkg::HOST_DATA_W,
    parameter int unsigned BANK_W      = lcr_pkg::BANK_IDX_W,
    parameter int unsigned SHARED_OFS  = lcr_pkg::OFS_SHARED,
    parameter int unsigned SHADOW_OFS  = lcr_pkg::OFS_SHADOW,
    parameter int unsigned SHADOW_BANK = lcr_pkg::BANK_SHADOW
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank_idx,
    input  logic [DATA_W-1:0] link_q,
    input  logic [DATA_W-1:0] bsel_q,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] rdata_d
);
    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_OFS);
    localparam logic [ADDR_W-1:0] SHADOW_A = ADDR_W'(SHADOW_OFS);
    localparam logic [BANK_W-1:0] SHADOW_B = BANK_W'(SHADOW_BANK);

    logic [DATA_W-1:0] sel_val;

    always_comb begin
        if (addr == SHARED_A) begin
            sel_val = bsel_q;
        end else if ((addr == SHADOW_A) && (bank_idx == SHADOW_B)) begin
            sel_val = link_q;
        end else begin
            sel_val = '0;
        end
        rdata_d = rd_en ? sel_val : rdata_q;
    end

endmodule

// File: rtl/lcr_fmt_unpack.sv
module lcr_fmt_unpack #(
    parameter int unsigned DATA_W = lcr_pkg::HOST_DATA_W
) (
    input  logic [DATA_W-1:0]   link_q,
    input  logic                cir_mode,
    output lcr_pkg::fmt_fields_t fmt
);
    import lcr_pkg::*;

    fmt_fields_t raw;

    always_comb begin
        raw.char_len  = link_q[FLD_LEN_LO +: 2];
        raw.stop_long = link_q[FLD_STOP];
        raw.par_en    = link_q[FLD_PAR_EN];
        raw.even      = link_q[FLD_EVEN];
        raw.stick     = link_q[FLD_STICK];
        raw.brk       = link_q[FLD_BREAK];
        // Framing fields have no meaning in consumer-IR mode
        fmt = cir_mode ? '0 : raw;
    end

endmodule

// File: rtl/lcr_bank_regs.sv
module lcr_bank_regs #(
    parameter int unsigned ADDR_W      = lcr_pkg::HOST_ADDR_W,
    parameter int unsigned DATA_W      = lcr_pkg::HOST_DATA_W,
    parameter int unsigned BANK_W      = lcr_pkg::BANK_IDX_W,
    parameter int unsigned SHARED_OFS  = lcr_pkg::OFS_SHARED,
    parameter int unsigned SHADOW_OFS  = lcr_pkg::OFS_SHADOW,
    parameter int unsigned SHADOW_BANK = lcr_pkg::BANK_SHADOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cir_mode,
    output logic [BANK_W-1:0] bank_idx,
    output logic [1:0]        fmt_char_len,
    output logic              fmt_stop_long,
    output logic              fmt_par_en,
    output logic              fmt_par_even,
    output logic              fmt_par_stick,
    output logic              fmt_break
);
    localparam int unsigned SEL_BIT = DATA_W - 1;
    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_OFS);

    typedef struct packed {
        logic [DATA_W-1:0] link;
        logic [DATA_W-1:0] bsel;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]     link_nx, bsel_nx, rdata_nx;
    lcr_pkg::fmt_fields_t  fmt;

    lcr_wr_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SHARED_OFS (SHARED_OFS)
    ) wr_ctrl_i (
        .wr_en  (host_wr),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .link_q (st_q.link),
        .bsel_q (st_q.bsel),
        .link_d (link_nx),
        .bsel_d (bsel_nx)
    );

    lcr_bank_dec #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) bank_dec_i (
        .bsel_q   (st_q.bsel),
        .bank_idx (bank_idx)
    );

    lcr_rd_mux #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BANK_W      (BANK_W),
        .SHARED_OFS  (SHARED_OFS),
        .SHADOW_OFS  (SHADOW_OFS),
        .SHADOW_BANK (SHADOW_BANK)
    ) rd_mux_i (
        .rd_en    (host_rd),
        .addr     (host_addr),
        .bank_idx (bank_idx),
        .link_q   (st_q.link),
        .bsel_q   (st_q.bsel),
        .rdata_q  (st_q.rdata),
        .rdata_d  (rdata_nx)
    );

    lcr_fmt_unpack #(
        .DATA_W (DATA_W)
    ) fmt_unpack_i (
        .link_q   (st_q.link),
        .cir_mode (cir_mode),
        .fmt      (fmt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.link  = link_nx;
        st_d.bsel  = bsel_nx;
        st_d.rdata = rdata_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata    = st_q.rdata;
    assign fmt_char_len  = fmt.char_len;
    assign fmt_stop_long = fmt.stop_long;
    assign fmt_par_en    = fmt.par_en;
    assign fmt_par_even  = fmt.even;
    assign fmt_par_stick = fmt.stick;
    assign fmt_break     = fmt.brk;

    // ---------------- assertions ----------------

    // R2: a shared-offset write always loads the bank selector
    p_bsel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SHARED_A) |=> (st_q.bsel == $past(host_wdata)));

    // R3: a selector-only write leaves the framing value untouched
    p_link_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SHARED_A && host_wdata[SEL_BIT])
            |=> (st_q.link == $past(st_q.link)));

    // R4: a read at the shared offset returns the selector seen before the edge
    p_rd_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SHARED_A) |=> (host_rdata == $past(st_q.bsel)));

    // R6: writes away from the shared offset change nothing
    p_other_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != SHARED_A)
            |=> ($stable(st_q.link) && $stable(st_q.bsel)));

    // R7: selector bit 7 clear means bank 0
    p_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.bsel[SEL_BIT]) |-> (bank_idx == '0));

    // R9: consumer-IR mode silences every framing output
    p_cir_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cir_mode |-> (fmt_char_len == 2'b00 && !fmt_stop_long && !fmt_par_en
                      && !fmt_par_even && !fmt_par_stick && !fmt_break));

    // R4: without a read strobe the read data holds
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd) |=> $stable(host_rdata));

endmodule

// File: tb/lcr_bank_regs_tb.sv
module lcr_bank_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       cir_mode = 1'b0;
    logic [1:0] bank_idx;
    logic [1:0] fmt_char_len;
    logic       fmt_stop_long, fmt_par_en, fmt_par_even, fmt_par_stick, fmt_break;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_link = 8'h00;
    logic [7:0] m_bsel = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    lcr_bank_regs dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .cir_mode      (cir_mode),
        .bank_idx      (bank_idx),
        .fmt_char_len  (fmt_char_len),
        .fmt_stop_long (fmt_stop_long),
        .fmt_par_en    (fmt_par_en),
        .fmt_par_even  (fmt_par_even),
        .fmt_par_stick (fmt_par_stick),
        .fmt_break     (fmt_break)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_bank(input logic [7:0] b);
        if (!b[7]) return 2'd0;
        if (b[1:0] == 2'd0) return 2'd1;
        return b[1:0];
    endfunction

    function automatic logic [7:0] fmt_word();
        return {1'b0, fmt_break, fmt_par_stick, fmt_par_even, fmt_par_en,
                fmt_stop_long, fmt_char_len};
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (a == 3'd3) begin
            m_bsel = d;
            if (!d[7]) m_link = d;
        end
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (a == 3'd3) return m_bsel;
        if (a == 3'd1 && exp_bank(m_bsel) == 2'd3) return m_link;
        return 8'h00;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 link/fmt", fmt_word(), 8'h00);
        check("R1 bank", {6'd0, bank_idx}, 8'h00);
        check("R1 rdata", host_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        host_read(3'd3, rd);
        check("R1 bsel readback", rd, 8'h00);

        // Exhaustive sweep of the shared-offset write value
        for (int v = 0; v < 256; v++) begin
            host_write(3'd3, 8'(v));
            // R2/R3/R8: framing outputs from model framing value
            check(v[7] ? "R3 link kept" : "R2 link loaded", fmt_word(), {1'b0, m_link[6:0]});
            // R7: bank decode
            check("R7 bank", {6'd0, bank_idx}, {6'd0, exp_bank(m_bsel)});
            // R9: consumer-IR silences fields without altering them
            cir_mode = 1'b1;
            #1;
            check("R9 cir quiet", fmt_word(), 8'h00);
            cir_mode = 1'b0;
            #1;
            check("R9 value kept", fmt_word(), {1'b0, m_link[6:0]});
            // R4: selector readback
            host_read(3'd3, rd);
            check("R4 shared read", rd, m_bsel);
            // R5/R10: shadow or empty location
            host_read(3'd1, rd);
            check(exp_bank(m_bsel) == 2'd3 ? "R5 shadow read" : "R10 other read",
                  rd, exp_read(3'd1));
            // R6: write to shadow / other offset ignored
            host_write(3'(1 + (v % 7 >= 2 ? v % 7 + 1 : v % 7)) , ~8'(v));
            host_read(3'd3, rd);
            check("R6 bsel untouched", rd, m_bsel);
            check("R6 link untouched", fmt_word(), {1'b0, m_link[6:0]});
        end

        // R10: every offset read in each bank, including shadow in bank 3
        for (int b = 0; b < 5; b++) begin
            logic [7:0] bv;
            bv = (b == 0) ? 8'h15 : (b == 1) ? 8'h80 : (b == 2) ? 8'h82
               : (b == 3) ? 8'h83 : 8'h81;
            host_write(3'd3, 8'h2A);
            host_write(3'd3, bv);
            for (int a = 0; a < 8; a++) begin
                host_read(3'(a), rd);
                check(a == 3 ? "R4 sweep" : (a == 1 && exp_bank(m_bsel) == 2'd3)
                      ? "R5 sweep" : "R10 sweep", rd, exp_read(3'(a)));
                // R6: reads leave both registers intact
                check("R6 read no side effect", fmt_word(), {1'b0, m_link[6:0]});
            end
        end

        // R4: read data holds without a strobe
        host_write(3'd3, 8'h83);
        host_read(3'd1, rd);
        repeat (3) @(negedge clk);
        check("R4 rdata hold", host_rdata, m_link);

        // R1: asynchronous reset returns everything to zero
        rst_n = 1'b0;
        #1;
        m_link = 8'h00; m_bsel = 8'h00;
        check("R1 reset fmt", fmt_word(), 8'h00);
        check("R1 reset bank", {6'd0, bank_idx}, 8'h00);
        check("R1 reset rdata", host_rdata, 8'h00);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule